// File: doc/BRIEF.md
# PLL Sequencer Register Bank with Key Unlock

This block extends an indexed sequencer register port. It holds the divider fields of two PLLs, one for the memory clock and one for the video clock, along with a PLL command byte and a key byte. Any index above the key index is shut until the key byte holds the unlock value. While the bank is shut, reads of those indices return a fixed, index-dependent value, and writes to them are dropped. A read-only index steps through a four-entry constant sequence, advancing once for each read it serves.

The block also turns two clock-select bits from the miscellaneous-output register into a pixel clock source code. It reports whether the PLL command asks for the pixel clock to be halved. It pulses a one-cycle reconfigure flag after every accepted command write. The PLL frequency is not computed here. The M, N and R fields are exposed for the clock logic downstream.

Software drives `idx` together with `wr_en` or `rd_en`. Write data is taken at the clock edge. `rdata` is a combinational function of `idx` and the current state, so it always shows the state before any write that lands on the same edge.

Top module: `pllseq_bank`

Access FSM states: `ACC_LOCKED` and `ACC_OPEN`. A key write equal to 0x06 takes the FSM to `ACC_OPEN`. A key write of any other value takes it to `ACC_LOCKED`.

Sequence FSM states: `SEQ_P0` → `SEQ_P1` → `SEQ_P2` → `SEQ_P3` → `SEQ_P0`. Each step is taken on a served read of index 0x17. Reset enters `SEQ_P0`.

## Requirements
- R1: After reset the key byte is 0x00, so the bank is locked. All PLL fields and the command byte are 0, the sequence sits at its first entry, and `reconfig` is low.
- R2: The key byte at index 0x08 is always writable and always readable. A write to any index above 0x08 changes nothing unless the key byte holds 0x06.
- R3: While locked, `rdata` for an index above 0x08 is 0x00 when the index is below 0x1B, and is the index value itself otherwise.
- R4: Index 0x10 is the memory PLL low byte and index 0x12 is the video PLL low byte. A write to a low byte sets N from bits 4:0 and R from bits 7:5. Index 0x11 is the memory PLL high byte and index 0x13 is the video PLL high byte. A write to a high byte sets M from bits 6:0. A low byte reads back as {R,N}. A high byte reads back as {0,M}.
- R5: Reads of index 0x17 return 0x7B, 0xC0, 0x00, 0xDA in turn, then wrap to 0x7B. The sequence advances only on an unlocked `rd_en` at 0x17. Locked reads and writes to 0x17 leave it where it is.
- R6: `clk_src` is 2'b00 when `clk_sel_in` is 0, which selects the 25.175 MHz source. It is 2'b01 when `clk_sel_in` is 1, which selects the 28.322 MHz source. It is 2'b10 (PLL) when `clk_sel_in` is 2 or 3.
- R7: Index 0x15 holds the PLL command byte, which reads back unchanged. `clk_halve` equals bit 4 of the command byte.
- R8: An accepted write to 0x15 raises `reconfig` for exactly the one cycle after the write edge. A locked write to 0x15 raises no pulse.
- R9: When unlocked, indices that hold no register read as 0x00. Writes to those indices are dropped.
- R10: When `rd_en` and `wr_en` target the same index in one cycle, `rdata` shows the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for `idx` |
| rd_en | input | 1 | Read strobe for `idx` |
| idx | input | 8 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `idx` (combinational) |
| clk_sel_in | input | 2 | Clock-select bits 3:2 of the miscellaneous-output register |
| mem_m | output | 7 | Memory PLL M field |
| mem_n | output | 5 | Memory PLL N field |
| mem_r | output | 3 | Memory PLL R field |
| vid_m | output | 7 | Video PLL M field |
| vid_n | output | 5 | Video PLL N field |
| vid_r | output | 3 | Video PLL R field |
| pll_cmd | output | 8 | PLL command byte |
| clk_src | output | 2 | Pixel clock source code |
| clk_halve | output | 1 | Pixel clock divided by two |
| reconfig | output | 1 | One-cycle pulse after an accepted command write |

## Verification
A read and a write can land on the same index in one cycle. The bench raises both strobes together in three cases:

- On the key index, where it re-locks the bank.
- On the command index.
- On the sequence index.

The captured `rdata` must be the old key, the old command, or the current sequence entry. The follow-up reads must then show the new key taking effect, the new command byte present, and the sequence advanced by exactly one step with the write dropped.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
    localparam int PLL_M_W = 7;
    localparam int PLL_N_W = 5;
    localparam int PLL_R_W = 3;

    typedef enum logic {
        ACC_LOCKED = 1'b0,
        ACC_OPEN   = 1'b1
    } acc_state_e;

    typedef enum logic [1:0] {
        SEQ_P0 = 2'd0,
        SEQ_P1 = 2'd1,
        SEQ_P2 = 2'd2,
        SEQ_P3 = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_FIX_LO = 2'b00,
        SRC_FIX_HI = 2'b01,
        SRC_PLL    = 2'b10
    } clk_src_e;

    typedef struct packed {
        logic [PLL_M_W-1:0] m;
        logic [PLL_N_W-1:0] n;
        logic [PLL_R_W-1:0] r;
    } pll_fields_t;
endpackage

// File: rtl/pllseq_gate.sv
module pllseq_gate
    import pllseq_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8,
    parameter logic [IDX_W-1:0]  KEY_IDX = 8'h08,
    parameter logic [DATA_W-1:0] KEY_VAL = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] key_q,
    output logic              open,
    output logic              wr_go
);
    acc_state_e state_q, state_d;
    logic [DATA_W-1:0] key_d;
    logic key_wr;

    assign key_wr = wr_en && (idx == KEY_IDX);

    always_comb begin
        state_d = state_q;
        key_d   = key_q;
        if (key_wr) begin
            key_d = wdata;
        end
        unique case (state_q)
            ACC_LOCKED: if (key_wr && (wdata == KEY_VAL)) state_d = ACC_OPEN;
            ACC_OPEN:   if (key_wr && (wdata != KEY_VAL)) state_d = ACC_LOCKED;
            default:    state_d = ACC_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_LOCKED;
            key_q   <= '0;
        end else begin
            state_q <= state_d;
            key_q   <= key_d;
        end
    end

    always_comb begin
        open  = (state_q == ACC_OPEN);
        wr_go = wr_en && open && (idx > KEY_IDX);
    end
endmodule

// File: rtl/pllseq_regs.sv
module pllseq_regs
    import pllseq_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int DATA_W  = 8,
    parameter int NUM_PLL = 2,
    parameter logic [IDX_W-1:0] PLL_BASE = 8'h10,
    parameter logic [IDX_W-1:0] CMD_IDX  = 8'h15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output pll_fields_t       plls [NUM_PLL],
    output logic [DATA_W-1:0] cmd_q,
    output logic              reconfig
);
    for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
        localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(PLL_BASE + 2 * g);
        localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(PLL_BASE + 2 * g + 1);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                plls[g] <= '0;
            end else if (wr_go && (idx == LO_IDX)) begin
                plls[g].n <= wdata[PLL_N_W-1:0];
                plls[g].r <= wdata[PLL_N_W +: PLL_R_W];
            end else if (wr_go && (idx == HI_IDX)) begin
                plls[g].m <= wdata[PLL_M_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            reconfig <= 1'b0;
        end else begin
            reconfig <= wr_go && (idx == CMD_IDX);
            if (wr_go && (idx == CMD_IDX)) cmd_q <= wdata;
        end
    end
endmodule

// File: rtl/pllseq_rdseq.sv
module pllseq_rdseq
    import pllseq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [4*DATA_W-1:0] SEQ_VALS = 32'hDA00C07B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [DATA_W-1:0] seq_val
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (adv) begin
            unique case (state_q)
                SEQ_P0: state_d = SEQ_P1;
                SEQ_P1: state_d = SEQ_P2;
                SEQ_P2: state_d = SEQ_P3;
                SEQ_P3: state_d = SEQ_P0;
                default: state_d = SEQ_P0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_P0;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SEQ_P0: seq_val = SEQ_VALS[0*DATA_W +: DATA_W];
            SEQ_P1: seq_val = SEQ_VALS[1*DATA_W +: DATA_W];
            SEQ_P2: seq_val = SEQ_VALS[2*DATA_W +: DATA_W];
            SEQ_P3: seq_val = SEQ_VALS[3*DATA_W +: DATA_W];
            default: seq_val = '0;
        endcase
    end
endmodule

// File: rtl/pllseq_clksel.sv
module pllseq_clksel
    import pllseq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int HALVE_BIT = 4
) (
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] cmd,
    output clk_src_e          src,
    output logic              halve
);
    always_comb begin
        unique case (sel)
            2'd0:    src = SRC_FIX_LO;
            2'd1:    src = SRC_FIX_HI;
            default: src = SRC_PLL;
        endcase
        halve = cmd[HALVE_BIT];
    end
endmodule

// File: rtl/pllseq_bank.sv
module pllseq_bank
    import pllseq_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 8,
    parameter logic [IDX_W-1:0]  KEY_IDX    = 8'h08,
    parameter logic [DATA_W-1:0] KEY_VAL    = 8'h06,
    parameter logic [IDX_W-1:0]  OPEN_LIMIT = 8'h1B,
    parameter logic [IDX_W-1:0]  PLL_BASE   = 8'h10,
    parameter logic [IDX_W-1:0]  CMD_IDX    = 8'h15,
    parameter logic [IDX_W-1:0]  SEQ_IDX    = 8'h17,
    parameter int HALVE_BIT = 4,
    parameter logic [4*DATA_W-1:0] SEQ_VALS = 32'hDA00C07B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [1:0]        clk_sel_in,
    output logic [PLL_M_W-1:0] mem_m,
    output logic [PLL_N_W-1:0] mem_n,
    output logic [PLL_R_W-1:0] mem_r,
    output logic [PLL_M_W-1:0] vid_m,
    output logic [PLL_N_W-1:0] vid_n,
    output logic [PLL_R_W-1:0] vid_r,
    output logic [DATA_W-1:0] pll_cmd,
    output logic [1:0]        clk_src,
    output logic              clk_halve,
    output logic              reconfig
);
    localparam int NUM_PLL = 2;
    localparam int MEM_SLOT = 0;
    localparam int VID_SLOT = 1;

    logic [DATA_W-1:0] key_q;
    logic              acc_open;
    logic              wr_go;
    pll_fields_t       plls [NUM_PLL];
    logic [DATA_W-1:0] seq_val;
    logic              seq_adv;
    clk_src_e          src_e;

    pllseq_gate #(.IDX_W(IDX_W), .DATA_W(DATA_W), .KEY_IDX(KEY_IDX), .KEY_VAL(KEY_VAL)) u_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .wdata(wdata),
        .key_q(key_q), .open(acc_open), .wr_go(wr_go)
    );

    pllseq_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W), .NUM_PLL(NUM_PLL),
                  .PLL_BASE(PLL_BASE), .CMD_IDX(CMD_IDX)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .idx(idx), .wdata(wdata),
        .plls(plls), .cmd_q(pll_cmd), .reconfig(reconfig)
    );

    assign seq_adv = rd_en && acc_open && (idx == SEQ_IDX);

    pllseq_rdseq #(.DATA_W(DATA_W), .SEQ_VALS(SEQ_VALS)) u_seq (
        .clk(clk), .rst_n(rst_n), .adv(seq_adv), .seq_val(seq_val)
    );

    pllseq_clksel #(.DATA_W(DATA_W), .HALVE_BIT(HALVE_BIT)) u_clk (
        .sel(clk_sel_in), .cmd(pll_cmd), .src(src_e), .halve(clk_halve)
    );

    assign clk_src = src_e;
    assign mem_m = plls[MEM_SLOT].m;
    assign mem_n = plls[MEM_SLOT].n;
    assign mem_r = plls[MEM_SLOT].r;
    assign vid_m = plls[VID_SLOT].m;
    assign vid_n = plls[VID_SLOT].n;
    assign vid_r = plls[VID_SLOT].r;

    always_comb begin
        rdata = '0;
        if (idx == KEY_IDX) begin
            rdata = key_q;
        end else if (idx > KEY_IDX && !acc_open) begin
            rdata = (idx < OPEN_LIMIT) ? '0 : DATA_W'(idx);
        end else if (idx > KEY_IDX) begin
            if (idx == CMD_IDX) rdata = pll_cmd;
            if (idx == SEQ_IDX) rdata = seq_val;
            for (int g = 0; g < NUM_PLL; g++) begin
                if (idx == IDX_W'(PLL_BASE + 2 * g))
                    rdata = DATA_W'({plls[g].r, plls[g].n});
                if (idx == IDX_W'(PLL_BASE + 2 * g + 1))
                    rdata = DATA_W'({1'b0, plls[g].m});
            end
        end
    end
endmodule

// File: rtl/pllseq_bank_chk.sv
module pllseq_bank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] idx,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [6:0] mem_m,
    input logic [4:0] mem_n,
    input logic [2:0] mem_r,
    input logic [7:0] pll_cmd,
    input logic [1:0] clk_src,
    input logic       clk_halve,
    input logic       reconfig,
    input logic       acc_open
);
    p_locked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_open && wr_en && idx > 8'h08) |=>
            ($stable(mem_m) && $stable(mem_n) && $stable(mem_r) && $stable(pll_cmd) && !reconfig));

    p_locked_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_open && idx > 8'h08 && idx < 8'h1B) |-> (rdata == 8'h00));

    p_low_pack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_open && wr_en && idx == 8'h10) |=>
            (mem_n == $past(wdata[4:0]) && mem_r == $past(wdata[7:5])));

    p_src_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_src != 2'b11);

    p_halve_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_open && wr_en && idx == 8'h15) |=> (clk_halve == $past(wdata[4])));

    p_reconfig_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reconfig |-> $past(acc_open && wr_en && idx == 8'h15));
endmodule

bind pllseq_bank pllseq_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .wdata(wdata), .rdata(rdata),
    .mem_m(mem_m), .mem_n(mem_n), .mem_r(mem_r), .pll_cmd(pll_cmd), .clk_src(clk_src),
    .clk_halve(clk_halve), .reconfig(reconfig), .acc_open(acc_open)
);

// File: tb/sim_pllseq_bank.sv
module sim_pllseq_bank;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] idx = '0, wdata = '0;
    logic [7:0] rdata;
    logic [1:0] clk_sel_in = '0;
    logic [6:0] mem_m, vid_m;
    logic [4:0] mem_n, vid_n;
    logic [2:0] mem_r, vid_r;
    logic [7:0] pll_cmd;
    logic [1:0] clk_src;
    logic clk_halve, reconfig;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pllseq_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .idx(idx), .wdata(wdata),
        .rdata(rdata), .clk_sel_in(clk_sel_in), .mem_m(mem_m), .mem_n(mem_n), .mem_r(mem_r),
        .vid_m(vid_m), .vid_n(vid_n), .vid_r(vid_r), .pll_cmd(pll_cmd), .clk_src(clk_src),
        .clk_halve(clk_halve), .reconfig(reconfig)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 0; rd_en = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] i, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; idx = i; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] i, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1; idx = i;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        rd(8'h08, v); chk("R1 key", v, 8'h00);
        chk("R1 mem fields", {mem_n, mem_r}, 8'h00);
        chk("R1 cmd", pll_cmd, 8'h00);
        chk("R1 reconfig", {7'd0, reconfig}, 8'h00);
        wr(8'h08, 8'h06);
        rd(8'h17, v); chk("R1 seq first", v, 8'h7B);
    endtask

    task automatic t_gating();
        logic [7:0] v;
        do_reset();
        wr(8'h10, 8'hAA);
        chk("R2 locked write n", {3'd0, mem_n}, 8'h00);
        wr(8'h08, 8'h05);
        rd(8'h08, v); chk("R2 key readback", v, 8'h05);
        wr(8'h11, 8'h33);
        chk("R2 wrong key write m", {1'b0, mem_m}, 8'h00);
        wr(8'h08, 8'h06);
        rd(8'h10, v); chk("R2 unlocked shows nothing written", v, 8'h00);
    endtask

    task automatic t_locked_reads();
        logic [7:0] v;
        do_reset();
        rd(8'h10, v); chk("R3 locked 0x10", v, 8'h00);
        rd(8'h1A, v); chk("R3 locked 0x1A", v, 8'h00);
        rd(8'h1B, v); chk("R3 locked 0x1B", v, 8'h1B);
        rd(8'hFF, v); chk("R3 locked 0xFF", v, 8'hFF);
    endtask

    task automatic t_fields();
        logic [7:0] v;
        do_reset();
        wr(8'h08, 8'h06);
        wr(8'h10, 8'hB7);
        chk("R4 mem n", {3'd0, mem_n}, 8'h17);
        chk("R4 mem r", {5'd0, mem_r}, 8'h05);
        wr(8'h11, 8'hFF);
        chk("R4 mem m", {1'b0, mem_m}, 8'h7F);
        wr(8'h12, 8'h41); wr(8'h13, 8'h35);
        chk("R4 vid n/r", {vid_r, vid_n}, 8'h41);
        chk("R4 vid m", {1'b0, vid_m}, 8'h35);
        rd(8'h10, v); chk("R4 read 0x10", v, 8'hB7);
        rd(8'h11, v); chk("R4 read 0x11", v, 8'h7F);
    endtask

    task automatic t_sequence();
        logic [7:0] v;
        logic [7:0] exp [5] = '{8'h7B, 8'hC0, 8'h00, 8'hDA, 8'h7B};
        do_reset();
        wr(8'h08, 8'h06);
        for (int k = 0; k < 5; k++) begin
            rd(8'h17, v); chk("R5 sequence", v, exp[k]);
        end
        wr(8'h08, 8'h00);
        rd(8'h17, v); chk("R5 locked seq read", v, 8'h00);
        wr(8'h08, 8'h06);
        rd(8'h17, v); chk("R5 no advance when locked", v, 8'hC0);
        wr(8'h17, 8'h55);
        rd(8'h17, v); chk("R5 write dropped", v, 8'h00);
    endtask

    task automatic t_clksel();
        do_reset();
        clk_sel_in = 2'd0; #1 chk("R6 sel0", {6'd0, clk_src}, 8'h00);
        clk_sel_in = 2'd1; #1 chk("R6 sel1", {6'd0, clk_src}, 8'h01);
        clk_sel_in = 2'd2; #1 chk("R6 sel2", {6'd0, clk_src}, 8'h02);
        clk_sel_in = 2'd3; #1 chk("R6 sel3", {6'd0, clk_src}, 8'h02);
        clk_sel_in = 2'd0;
    endtask

    task automatic t_cmd();
        logic [7:0] v;
        do_reset();
        wr(8'h15, 8'h10);
        chk("R8 locked no pulse", {7'd0, reconfig}, 8'h00);
        chk("R7 locked cmd", pll_cmd, 8'h00);
        wr(8'h08, 8'h06);
        @(negedge clk);
        wr_en = 1; idx = 8'h15; wdata = 8'h10;
        #1 chk("R8 low before edge", {7'd0, reconfig}, 8'h00);
        @(negedge clk);
        wr_en = 0;
        #1 chk("R8 pulse high", {7'd0, reconfig}, 8'h01);
        chk("R7 halve set", {7'd0, clk_halve}, 8'h01);
        @(negedge clk);
        #1 chk("R8 pulse one cycle", {7'd0, reconfig}, 8'h00);
        rd(8'h15, v); chk("R7 cmd readback", v, 8'h10);
        wr(8'h15, 8'hEF);
        chk("R7 halve clear", {7'd0, clk_halve}, 8'h00);
    endtask

    task automatic t_unknown();
        logic [7:0] v;
        do_reset();
        wr(8'h08, 8'h06);
        rd(8'h14, v); chk("R9 read 0x14", v, 8'h00);
        rd(8'h30, v); chk("R9 read 0x30", v, 8'h00);
        rd(8'h03, v); chk("R9 read 0x03", v, 8'h00);
        wr(8'h14, 8'hFF);
        rd(8'h14, v); chk("R9 write dropped", v, 8'h00);
        chk("R9 cmd untouched", pll_cmd, 8'h00);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        do_reset();
        wr(8'h08, 8'h06);
        wr(8'h15, 8'h33);
        @(negedge clk);
        wr_en = 1; rd_en = 1; idx = 8'h15; wdata = 8'h44;
        #1 v = rdata;
        @(negedge clk); wr_en = 0; rd_en = 0;
        chk("R10 cmd old value", v, 8'h33);
        rd(8'h15, v); chk("R10 cmd new value", v, 8'h44);
        @(negedge clk);
        wr_en = 1; rd_en = 1; idx = 8'h17; wdata = 8'h99;
        #1 v = rdata;
        @(negedge clk); wr_en = 0; rd_en = 0;
        chk("R10 seq read on write", v, 8'h7B);
        rd(8'h17, v); chk("R10 seq advanced once", v, 8'hC0);
        @(negedge clk);
        wr_en = 1; rd_en = 1; idx = 8'h08; wdata = 8'h00;
        #1 v = rdata;
        @(negedge clk); wr_en = 0; rd_en = 0;
        chk("R10 key old value", v, 8'h06);
        rd(8'h15, v); chk("R10 relocked", v, 8'h00);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_gating();
        t_locked_reads();
        t_fields();
        t_sequence();
        t_clksel();
        t_cmd();
        t_unknown();
        t_same_cycle();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule